// File: doc/BRIEF.md
# USB device address control

This block holds the USB device address and the device enable flag that a host microprocessor programs, and it derives from them the live address and live enable that the device's packet matcher uses. The processor uses a small command/data port: it first strobes in a command byte, then moves exactly one data byte. One command code selects a register write and a second one selects a register read.

The block keeps the processor-visible register apart from the live state. A newly written address is not used straight away. It waits as a pending value until the device core reports that the host has acknowledged the zero-length status packet that completes the address request. Only then is it copied to the live address. The enable bit takes effect as soon as it is written.

A USB bus reset indication sets the live address to zero and turns the live enable on. It also drops any pending address. The register the processor reads back is not changed by a bus reset.

Top module: `usb_devaddr_ctrl`

## Requirements
- R1: After `rst`, the register reads 00h, and `live_addr` = 0, `live_en` = 0, `addr_pending` = 0 and `rd_byte` = 00h.
- R2: The register is one byte wide: bit 7 is the enable and bits 6..0 are the address. After command B6h, a `dat_we` strobe stores `wr_byte`. After command B7h, a `dat_re` strobe places the register on `rd_byte` from the next cycle, where it holds until the next read.
- R3: A command allows exactly one data transfer. A second `dat_we` that is not preceded by a new command leaves the register unchanged.
- R4: A `dat_we` under any command code other than B6h does not change the register. A `dat_re` under any code other than B7h does not change `rd_byte`.
- R5: On the cycle after a register write, `live_en` equals bit 7 of the written byte.
- R6: On the cycle after a register write, `addr_pending` is 1 and `live_addr` still holds its previous value.
- R7: A `status_ack` pulse while `addr_pending` is 1 loads the most recently written address into `live_addr` on the next cycle and clears `addr_pending`.
- R8: A `status_ack` pulse while `addr_pending` is 0 changes neither `live_addr` nor `live_en`.
- R9: A `bus_rst` pulse sets `live_addr` = 0, `live_en` = 1 and `addr_pending` = 0 on the next cycle. A later `status_ack` does not restore the cancelled address, and the register read back is unchanged.
- R10: If a second write arrives before the acknowledge, it replaces the pending address. Only the last written address goes live.
- R11: If `bus_rst` falls in the same cycle as a register write, the register takes the byte and the live state follows R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command code (B6h write, B7h read) |
| dat_we | input | 1 | Data write strobe |
| wr_byte | input | 8 | Data byte to write |
| dat_re | input | 1 | Data read strobe |
| rd_byte | output | 8 | Registered read data |
| bus_rst | input | 1 | USB bus reset pulse, one clock wide |
| status_ack | input | 1 | Status-stage acknowledge pulse, one clock wide |
| live_addr | output | 7 | Address used for packet matching |
| live_en | output | 1 | Live device enable |
| addr_pending | output | 1 | An address awaits activation |

## Verification
Every result of this block is registered. The register write, `rd_byte`, `live_en`, `addr_pending` and `live_addr` therefore each change at the first rising edge that samples the causing strobe, and they are due exactly one cycle after it. The bench drives each strobe for one cycle starting at a falling edge and checks the outputs at the following falling edge, half a cycle after the edge that updated them. A stable result is also checked again after a further acknowledge pulse. The bench sweeps all 256 write values and all 256 command codes against a shadow copy of the register.

// File: rtl/usb_devaddr_pkg.sv
package usb_devaddr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } addr_op_e;
endpackage

// File: rtl/usb_devaddr_cmd.sv
module usb_devaddr_cmd
  import usb_devaddr_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] WR_CODE = 8'hB6,
  parameter logic [CMD_W-1:0] RD_CODE = 8'hB7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             dat_we,
  input  logic             dat_re,
  output logic             wr_stb,
  output logic             rd_stb
);
  addr_op_e op_q;

  assign wr_stb = dat_we && (op_q == OP_WRITE);
  assign rd_stb = dat_re && (op_q == OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= OP_IDLE;
    end else if (cmd_we) begin
      if (cmd_byte == WR_CODE)      op_q <= OP_WRITE;
      else if (cmd_byte == RD_CODE) op_q <= OP_READ;
      else                          op_q <= OP_IDLE;
    end else if (wr_stb || rd_stb) begin
      op_q <= OP_IDLE;
    end
  end

  // R3
  one_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr_stb || rd_stb) && !cmd_we) |=> (op_q == OP_IDLE));
endmodule

// File: rtl/usb_devaddr_reg.sv
module usb_devaddr_reg #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_byte,
  input  logic             rd_stb,
  output logic [REG_W-1:0] reg_q,
  output logic [REG_W-1:0] rd_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= '0;
      rd_byte <= '0;
    end else begin
      if (wr_stb) reg_q   <= wr_byte;
      if (rd_stb) rd_byte <= reg_q;
    end
  end

  // R2
  reg_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (reg_q == $past(wr_byte)));
  // R4
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(reg_q));
endmodule

// File: rtl/usb_devaddr_live.sv
module usb_devaddr_live #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en,
  input  logic              bus_rst,
  input  logic              status_ack,
  output logic [ADDR_W-1:0] live_addr,
  output logic              live_en,
  output logic              addr_pending
);
  logic [ADDR_W-1:0] pend_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_addr    <= '0;
      live_en      <= 1'b0;
      addr_pending <= 1'b0;
      pend_addr    <= '0;
    end else begin
      if (wr_stb) pend_addr <= wr_addr;
      if (bus_rst) begin
        live_addr    <= '0;
        live_en      <= 1'b1;
        addr_pending <= 1'b0;
      end else if (wr_stb) begin
        live_en      <= wr_en;
        addr_pending <= 1'b1;
      end else if (status_ack && addr_pending) begin
        live_addr    <= pend_addr;
        addr_pending <= 1'b0;
      end
    end
  end

  // R9
  bus_rst_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (live_addr == '0 && live_en && !addr_pending));
  // R5
  en_live_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !bus_rst) |=> (live_en == $past(wr_en)));
  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !bus_rst) |=> (addr_pending && $stable(live_addr)));
  // R7
  ack_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (status_ack && addr_pending && !wr_stb && !bus_rst) |=>
      (!addr_pending && live_addr == $past(pend_addr)));
  // R8
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (status_ack && !addr_pending && !wr_stb && !bus_rst) |=>
      ($stable(live_addr) && $stable(live_en)));
endmodule

// File: rtl/usb_devaddr_ctrl.sv
module usb_devaddr_ctrl #(
  parameter int ADDR_W = 7,
  parameter int CMD_W  = 8,
  parameter logic [CMD_W-1:0] WR_CODE = 8'hB6,
  parameter logic [CMD_W-1:0] RD_CODE = 8'hB7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic              dat_we,
  input  logic [ADDR_W:0]   wr_byte,
  input  logic              dat_re,
  output logic [ADDR_W:0]   rd_byte,
  input  logic              bus_rst,
  input  logic              status_ack,
  output logic [ADDR_W-1:0] live_addr,
  output logic              live_en,
  output logic              addr_pending
);
  localparam int REG_W = ADDR_W + 1;

  logic             wr_stb;
  logic             rd_stb;
  logic [REG_W-1:0] reg_q;

  usb_devaddr_cmd #(
    .CMD_W(CMD_W), .WR_CODE(WR_CODE), .RD_CODE(RD_CODE)
  ) u_cmd (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .dat_we(dat_we), .dat_re(dat_re), .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  usb_devaddr_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .rd_stb(rd_stb), .reg_q(reg_q), .rd_byte(rd_byte)
  );

  usb_devaddr_live #(.ADDR_W(ADDR_W)) u_live (
    .clk(clk), .rst(rst), .wr_stb(wr_stb),
    .wr_addr(wr_byte[ADDR_W-1:0]), .wr_en(wr_byte[ADDR_W]),
    .bus_rst(bus_rst), .status_ack(status_ack),
    .live_addr(live_addr), .live_en(live_en), .addr_pending(addr_pending)
  );

  // R1
  rd_reset_chk: assert property (@(posedge clk)
    rst |=> (rd_byte == '0 && !addr_pending && !live_en));
endmodule

// File: tb/usb_devaddr_ctrl_test.sv
`timescale 1ns/1ps
module usb_devaddr_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       dat_we = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       dat_re = 1'b0;
  logic [7:0] rd_byte;
  logic       bus_rst = 1'b0;
  logic       status_ack = 1'b0;
  logic [6:0] live_addr;
  logic       live_en;
  logic       addr_pending;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0] shadow;

  always #2.5 clk = ~clk;

  usb_devaddr_ctrl uut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .dat_we(dat_we), .wr_byte(wr_byte), .dat_re(dat_re), .rd_byte(rd_byte),
    .bus_rst(bus_rst), .status_ack(status_ack), .live_addr(live_addr),
    .live_en(live_en), .addr_pending(addr_pending)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // each task: drive at a falling edge, release at the next falling edge
  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_byte = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic send_data(input logic [7:0] d, input logic brst);
    @(negedge clk); dat_we = 1'b1; wr_byte = d; bus_rst = brst;
    @(negedge clk); dat_we = 1'b0; bus_rst = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    send_cmd(8'hB6);
    send_data(d, 1'b0);
  endtask

  task automatic pulse_re();
    @(negedge clk); dat_re = 1'b1;
    @(negedge clk); dat_re = 1'b0;
  endtask

  task automatic do_read();
    send_cmd(8'hB7);
    pulse_re();
  endtask

  task automatic pulse_ack();
    @(negedge clk); status_ack = 1'b1;
    @(negedge clk); status_ack = 1'b0;
  endtask

  task automatic pulse_brst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  initial begin
    logic [6:0] prev_live;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 live_addr", live_addr, 0);
    check("R1 live_en", live_en, 0);
    check("R1 pending", addr_pending, 0);
    check("R1 rd_byte", rd_byte, 0);
    do_read();
    check("R1 reg", rd_byte, 0);

    // R2 R5 R6 R7 R8 sweep over every register value
    for (int v = 0; v < 256; v++) begin
      prev_live = live_addr;
      do_write(8'(v));
      check("R5 en live", live_en, (v >> 7) & 1);
      check("R6 pending", addr_pending, 1);
      check("R6 addr held", live_addr, prev_live);
      do_read();
      check("R2 readback", rd_byte, v);
      pulse_ack();
      check("R7 addr live", live_addr, v & 8'h7F);
      check("R7 pending clr", addr_pending, 0);
      pulse_ack();
      check("R8 addr stable", live_addr, v & 8'h7F);
      check("R8 en stable", live_en, (v >> 7) & 1);
    end

    // R3 one byte per command
    do_write(8'h15);
    send_data(8'h6A, 1'b0);
    do_read();
    check("R3 second byte ignored", rd_byte, 8'h15);
    pulse_ack();

    // R4 every other command code
    shadow = 8'h15;
    for (int c = 0; c < 256; c++) begin
      if (c != 8'hB6) begin
        send_cmd(8'(c));
        send_data(8'(c) ^ 8'h5A, 1'b0);
        if (c != 8'hB7) begin
          pulse_re();
          check("R4 rd_byte held", rd_byte, shadow);
        end
        do_read();
        check("R4 reg unchanged", rd_byte, shadow);
      end
    end

    // R9 bus reset cancels pending address
    do_write(8'h85);
    pulse_brst();
    check("R9 addr zero", live_addr, 0);
    check("R9 en set", live_en, 1);
    check("R9 pending clr", addr_pending, 0);
    pulse_ack();
    check("R9 ack after reset", live_addr, 0);
    do_read();
    check("R9 reg kept", rd_byte, 8'h85);
    do_write(8'h00);
    pulse_ack();
    check("R9 disabled first", live_en, 0);
    pulse_brst();
    check("R9 en from disabled", live_en, 1);

    // R10 later write replaces pending
    do_write(8'h8A);
    do_write(8'h93);
    check("R10 still old", live_addr, 0);
    pulse_ack();
    check("R10 last wins", live_addr, 8'h13);
    check("R10 pending clr", addr_pending, 0);

    // R11 bus reset in the write cycle
    send_cmd(8'hB6);
    send_data(8'h9C, 1'b1);
    check("R11 addr zero", live_addr, 0);
    check("R11 en", live_en, 1);
    check("R11 no pending", addr_pending, 0);
    do_read();
    check("R11 reg written", rd_byte, 8'h9C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule